// File: doc/BRIEF.md
# Lagging Thread Selection Unit

This block keeps one progress counter per hardware thread and uses those counters to decide which thread is falling behind. Each counter counts committed-instruction pulses. A barrier-clear input zeroes all counters, since threads are expected to commit roughly the same number of instructions between barriers. Each counter stops at its largest value and does not wrap.

A one-cycle quantum-end pulse starts an evaluation. The unit finds the smallest progress count among the enabled threads. It then flags as lagging every enabled thread whose count is strictly below that minimum plus a programmable margin. From the flagged set it picks the thread with the highest utility score. The scores are supplied from outside, one per thread. The flag mask, the chosen index and a valid bit are registered and hold until the next quantum ends. A scheduler reads them to decide which thread moves to a fast core.

Top module: `lag_thread_select`

## Requirements
- R1: Each commit pulse on a thread adds one to that thread's progress count. All counts and all outputs are zero after reset.
- R2: A progress count that has reached its largest value (all ones, 63 for a 6-bit count) stays there when further commit pulses arrive.
- R3: A barrier-clear pulse sets every progress count to zero. When barrier-clear and a commit pulse arrive in the same cycle, the count is still zero afterwards.
- R4: The minimum progress is taken only over threads whose enable bit is 1. A thread with enable 0 is never flagged and never chosen.
- R5: An enabled thread is flagged lagging when its count is strictly below the minimum plus the margin. The sum is formed one bit wider than the count, so it never wraps. A margin of zero flags no thread.
- R6: The chosen thread is the flagged thread with the largest utility value. Thread i's utility sits at bits [i*UTIL_W +: UTIL_W] of the utility bus, read as unsigned.
- R7: When flagged threads tie on utility, the lowest thread index is chosen.
- R8: The outputs change only at the clock edge that samples quantum-end high, and then hold. That evaluation uses the counts as they stood before that edge.
- R9: The valid output is 1 exactly when the lag mask is non-zero. When the mask is zero (no thread enabled, or margin zero), the valid output is 0 and the chosen index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| barrier_clr | input | 1 | Zeroes every progress count |
| commit_pulse | input | NTHR | One commit pulse per thread per cycle |
| thread_en | input | NTHR | Threads taking part in the evaluation |
| margin | input | CNT_W | Margin added to the minimum progress |
| utility | input | NTHR*UTIL_W | Packed per-thread utility scores |
| quantum_end | input | 1 | Starts an evaluation |
| lag_mask | output | NTHR | Registered set of lagging threads |
| sel_idx | output | IDX_W | Registered index of the chosen thread |
| sel_valid | output | 1 | The chosen index is meaningful |

## Verification
The bench sweeps every enable pattern against several margins, count sets and utility patterns, and targets these corner cases:
- Saturated counters: a counter that wrapped would make a busy thread look like the slowest.
- A minimum plus margin that overflows the count width: a narrow sum would wrap and flag no thread at all.
- Utility ties and disabled threads: getting these wrong picks a higher index, or a thread outside the enable set.
- Barrier-clear colliding with a commit pulse, and quantum-end colliding with a commit pulse: a wrong priority or sampling point leaves a thread with count one and drops it from the mask.

// File: rtl/lag_sel_pkg.sv
package lag_sel_pkg;
    // Width of an index into a set of n items, never below one bit.
    function automatic int idx_width(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/lag_progress_bank.sv
module lag_progress_bank #(
    parameter int NTHR  = 4,
    parameter int CNT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic [NTHR-1:0]         inc,
    output logic [NTHR*CNT_W-1:0]   cnt_flat
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [NTHR-1:0][CNT_W-1:0] cnt;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NTHR; i++) begin
            if (clr) begin
                bank_d.cnt[i] = '0;
            end else if (inc[i] && (bank_q.cnt[i] != CNT_MAX)) begin
                bank_d.cnt[i] = bank_q.cnt[i] + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign cnt_flat = bank_q.cnt;
endmodule

// File: rtl/lag_min_finder.sv
module lag_min_finder #(
    parameter int NTHR  = 4,
    parameter int CNT_W = 8
) (
    input  logic [NTHR*CNT_W-1:0] cnt_flat,
    input  logic [NTHR-1:0]       en,
    output logic [CNT_W-1:0]      min_val,
    output logic                  any_en
);
    logic [CNT_W-1:0] cnt_a [NTHR];

    for (genvar g = 0; g < NTHR; g++) begin : g_unpack
        assign cnt_a[g] = cnt_flat[g*CNT_W +: CNT_W];
    end

    logic [CNT_W-1:0] m_w;
    logic             f_w;

    always_comb begin
        m_w = '1;
        f_w = 1'b0;
        for (int i = 0; i < NTHR; i++) begin
            if (en[i] && (!f_w || (cnt_a[i] < m_w))) begin
                m_w = cnt_a[i];
                f_w = 1'b1;
            end
        end
    end

    assign min_val = m_w;
    assign any_en  = f_w;
endmodule

// File: rtl/lag_util_picker.sv
module lag_util_picker
    import lag_sel_pkg::*;
#(
    parameter int NTHR   = 4,
    parameter int CNT_W  = 8,
    parameter int UTIL_W = 4,
    localparam int IDX_W = idx_width(NTHR)
) (
    input  logic [NTHR*CNT_W-1:0]  cnt_flat,
    input  logic [NTHR-1:0]        en,
    input  logic [CNT_W-1:0]       min_val,
    input  logic                   any_en,
    input  logic [CNT_W-1:0]       margin,
    input  logic [NTHR*UTIL_W-1:0] util_flat,
    output logic [NTHR-1:0]        lag,
    output logic [IDX_W-1:0]       sel,
    output logic                   sel_ok
);
    // One extra bit keeps min + margin from wrapping.
    logic [CNT_W:0] thresh;
    assign thresh = {1'b0, min_val} + {1'b0, margin};

    logic [UTIL_W-1:0] util_a [NTHR];

    for (genvar g = 0; g < NTHR; g++) begin : g_flag
        assign util_a[g] = util_flat[g*UTIL_W +: UTIL_W];
        assign lag[g]    = any_en && en[g] &&
                           ({1'b0, cnt_flat[g*CNT_W +: CNT_W]} < thresh);
    end

    logic [UTIL_W-1:0] best_u;
    logic [IDX_W-1:0]  best_i;
    logic              found;

    always_comb begin
        best_u = '0;
        best_i = '0;
        found  = 1'b0;
        // Strict greater-than keeps the lower index on ties.
        for (int i = 0; i < NTHR; i++) begin
            if (lag[i] && (!found || (util_a[i] > best_u))) begin
                best_u = util_a[i];
                best_i = IDX_W'(i);
                found  = 1'b1;
            end
        end
    end

    assign sel    = best_i;
    assign sel_ok = found;
endmodule

// File: rtl/lag_thread_select.sv
module lag_thread_select
    import lag_sel_pkg::*;
#(
    parameter int NTHR   = 4,
    parameter int CNT_W  = 8,
    parameter int UTIL_W = 4,
    localparam int IDX_W = idx_width(NTHR)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   barrier_clr,
    input  logic [NTHR-1:0]        commit_pulse,
    input  logic [NTHR-1:0]        thread_en,
    input  logic [CNT_W-1:0]       margin,
    input  logic [NTHR*UTIL_W-1:0] utility,
    input  logic                   quantum_end,
    output logic [NTHR-1:0]        lag_mask,
    output logic [IDX_W-1:0]       sel_idx,
    output logic                   sel_valid
);
    typedef struct packed {
        logic [NTHR-1:0]  mask;
        logic [IDX_W-1:0] idx;
        logic             vld;
    } pick_t;

    logic [NTHR*CNT_W-1:0] cnt_flat;
    logic [CNT_W-1:0]      min_val;
    logic                  any_en;
    logic [NTHR-1:0]       lag_c;
    logic [IDX_W-1:0]      sel_c;
    logic                  ok_c;

    lag_progress_bank #(.NTHR(NTHR), .CNT_W(CNT_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (barrier_clr),
        .inc      (commit_pulse),
        .cnt_flat (cnt_flat)
    );

    lag_min_finder #(.NTHR(NTHR), .CNT_W(CNT_W)) u_min (
        .cnt_flat (cnt_flat),
        .en       (thread_en),
        .min_val  (min_val),
        .any_en   (any_en)
    );

    lag_util_picker #(.NTHR(NTHR), .CNT_W(CNT_W), .UTIL_W(UTIL_W)) u_pick (
        .cnt_flat  (cnt_flat),
        .en        (thread_en),
        .min_val   (min_val),
        .any_en    (any_en),
        .margin    (margin),
        .util_flat (utility),
        .lag       (lag_c),
        .sel       (sel_c),
        .sel_ok    (ok_c)
    );

    pick_t pick_d, pick_q;

    always_comb begin
        pick_d = pick_q;
        if (quantum_end) begin
            pick_d.mask = lag_c;
            pick_d.idx  = ok_c ? sel_c : '0;
            pick_d.vld  = ok_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pick_q <= '0;
        end else begin
            pick_q <= pick_d;
        end
    end

    assign lag_mask  = pick_q.mask;
    assign sel_idx   = pick_q.idx;
    assign sel_valid = pick_q.vld;
endmodule

// File: rtl/lag_thread_select_chk.sv
module lag_thread_select_chk #(
    parameter int NTHR  = 4,
    parameter int CNT_W = 8,
    parameter int IDX_W = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  barrier_clr,
    input logic                  quantum_end,
    input logic [NTHR-1:0]       thread_en,
    input logic [NTHR*CNT_W-1:0] cnt_flat,
    input logic [NTHR-1:0]       lag_mask,
    input logic [IDX_W-1:0]      sel_idx,
    input logic                  sel_valid
);
    // R9
    valid_tracks_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid == (lag_mask != '0));

    // R6
    sel_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> lag_mask[sel_idx]);

    // R4
    mask_within_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(quantum_end) |-> ((lag_mask & ~$past(thread_en)) == '0));

    // R8
    hold_between_quanta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(quantum_end) |-> ($stable(lag_mask) && $stable(sel_idx) && $stable(sel_valid)));

    // R3
    barrier_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(barrier_clr) |-> (cnt_flat == '0));

    for (genvar g = 0; g < NTHR; g++) begin : g_mono
        // R1
        count_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(barrier_clr) |->
                (cnt_flat[g*CNT_W +: CNT_W] >= $past(cnt_flat[g*CNT_W +: CNT_W])));
    end
endmodule

bind lag_thread_select lag_thread_select_chk #(
    .NTHR(NTHR), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .barrier_clr (barrier_clr),
    .quantum_end (quantum_end),
    .thread_en   (thread_en),
    .cnt_flat    (cnt_flat),
    .lag_mask    (lag_mask),
    .sel_idx     (sel_idx),
    .sel_valid   (sel_valid)
);

// File: tb/tb_lag_thread_select.sv
module tb_lag_thread_select;
    localparam int PERIOD = 10;
    localparam int NT  = 4;
    localparam int CW  = 6;
    localparam int UW  = 3;
    localparam int CMX = 63;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              barrier_clr = 1'b0;
    logic [NT-1:0]     commit_pulse = '0;
    logic [NT-1:0]     thread_en = '0;
    logic [CW-1:0]     margin = '0;
    logic [NT*UW-1:0]  utility = '0;
    logic              quantum_end = 1'b0;
    logic [NT-1:0]     lag_mask;
    logic [1:0]        sel_idx;
    logic              sel_valid;

    int n_chk = 0;
    int n_fail = 0;
    int mcnt [NT];
    logic [NT-1:0] prev_mask = '0;
    int            prev_idx  = 0;
    logic          prev_vld  = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    lag_thread_select #(.NTHR(NT), .CNT_W(CW), .UTIL_W(UW)) dut (
        .clk(clk), .rst_n(rst_n), .barrier_clr(barrier_clr),
        .commit_pulse(commit_pulse), .thread_en(thread_en), .margin(margin),
        .utility(utility), .quantum_end(quantum_end),
        .lag_mask(lag_mask), .sel_idx(sel_idx), .sel_valid(sel_valid)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_counts(input int c0, input int c1, input int c2, input int c3);
        int c [NT];
        int mx;
        c[0] = c0; c[1] = c1; c[2] = c2; c[3] = c3;
        barrier_clr = 1'b1;
        @(negedge clk);
        barrier_clr = 1'b0;
        for (int i = 0; i < NT; i++) mcnt[i] = 0;
        mx = 0;
        for (int i = 0; i < NT; i++) if (c[i] > mx) mx = c[i];
        for (int k = 0; k < mx; k++) begin
            for (int i = 0; i < NT; i++) begin
                commit_pulse[i] = (k < c[i]);
                if (k < c[i] && mcnt[i] < CMX) mcnt[i]++;
            end
            @(negedge clk);
        end
        commit_pulse = '0;
        // R8: no quantum end, outputs must still hold the last result
        check("R8", "held mask", int'(lag_mask), int'(prev_mask));
        check("R8", "held valid", int'(sel_valid), int'(prev_vld));
    endtask

    task automatic quantum(input string req, input logic [NT-1:0] en, input int marg,
                           input int u0, input int u1, input int u2, input int u3);
        int u [NT];
        int mn, best, eidx;
        logic [NT-1:0] em;
        u[0] = u0; u[1] = u1; u[2] = u2; u[3] = u3;
        thread_en = en;
        margin = CW'(marg);
        for (int i = 0; i < NT; i++) utility[i*UW +: UW] = UW'(u[i]);
        mn = -1;
        for (int i = 0; i < NT; i++) if (en[i] && (mn < 0 || mcnt[i] < mn)) mn = mcnt[i];
        em = '0;
        for (int i = 0; i < NT; i++) if (en[i] && mcnt[i] < mn + marg) em[i] = 1'b1;
        best = -1; eidx = 0;
        for (int i = 0; i < NT; i++) if (em[i] && u[i] > best) begin best = u[i]; eidx = i; end
        quantum_end = 1'b1;
        @(negedge clk);
        quantum_end = 1'b0;
        check(req, "lag mask", int'(lag_mask), int'(em));
        check(req, "valid", int'(sel_valid), int'(em != '0));
        check(req, "index", int'(sel_idx), eidx);
        prev_mask = em; prev_idx = eidx; prev_vld = (em != '0);
    endtask

    initial begin
        #(PERIOD*200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int mlist [5];
        mlist[0] = 0; mlist[1] = 1; mlist[2] = 2; mlist[3] = 5; mlist[4] = 63;
        repeat (3) @(negedge clk);
        // R10-style reset state, tagged R1
        check("R1", "reset mask", int'(lag_mask), 0);
        check("R1", "reset valid", int'(sel_valid), 0);
        check("R1", "reset index", int'(sel_idx), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int s = 0; s < 3; s++) begin
            if (s == 0) set_counts(5, 9, 5, 12);
            else if (s == 1) set_counts(70, 60, 61, 66);   // R2 saturation, R5 wide sum
            else set_counts(0, 3, 1, 2);
            for (int e = 0; e < 16; e++) begin
                for (int m = 0; m < 5; m++) begin
                    // R4 R5 R6 R7 R9 sweep: ties on 1/2 then all equal
                    quantum("R6", 4'(e), mlist[m], 3, 7, 7, 1);
                    quantum("R7", 4'(e), mlist[m], 5, 5, 5, 5);
                end
            end
        end

        // R3: barrier clear beats a same-cycle commit
        set_counts(5, 5, 5, 5);
        barrier_clr = 1'b1;
        commit_pulse = 4'b0010;
        @(negedge clk);
        barrier_clr = 1'b0;
        commit_pulse = '0;
        for (int i = 0; i < NT; i++) mcnt[i] = 0;
        quantum("R3", 4'b1111, 1, 1, 2, 3, 4);

        // R8: evaluation uses counts from before the sampling edge
        commit_pulse = 4'b0001;
        thread_en = 4'b1111;
        margin = CW'(1);
        utility = '0;
        quantum_end = 1'b1;
        @(negedge clk);
        quantum_end = 1'b0;
        commit_pulse = '0;
        check("R8", "same-edge mask", int'(lag_mask), 15);
        mcnt[0] = 1;
        quantum("R1", 4'b1111, 1, 0, 0, 0, 0);   // thread 0 now ahead by one

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule